// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This combinational unit sits between a 32-bit processor datapath and a little-endian 32-bit data bus. On the store side, it spreads the outgoing operand across the four byte lanes and produces one write-enable bit per lane. The bus then keeps only the lanes that are enabled, so the data never has to be shifted to the target offset.

On the load side, it moves the addressed byte, halfword or word of the returned bus word down to bit 0. It then widens the value to 32 bits with sign or zero fill.

The access width and signedness come from a 3-bit access code, and the lane offset comes from the two low address bits. Addresses that are not naturally aligned produce no trap. Instead, lane enables that would fall past the top lane are simply dropped.

Top module: `byte_lane_align`

## Requirements
- R1: With access code 000 (byte), the write data carries store_data[7:0] in all four byte lanes.
- R2: With access code 001 (halfword), the write data carries store_data[15:0] in both 16-bit halves.
- R3: With any access code other than 000 and 001, the write data equals store_data unchanged.
- R4: With store_en high and access code 000 or 100, the lane enables are 4'b0001 shifted left by addr_lo.
- R5: With store_en high and access code 001 or 101, the lane enables are 4'b0011 shifted left by addr_lo and cut to 4 bits, so offset 3 gives 4'b1000.
- R6: With store_en high, access code 010 gives lane enables 4'b1111 at every offset, and codes 011, 110 and 111 give 4'b0000.
- R7: With store_en low, the lane enables are 4'b0000 whatever the other inputs are.
- R8: The loaded value for a word access (code 010) is read_data shifted right by 8*addr_lo, with zeros filled in at the top.
- R9: A signed byte load (code 000) or signed halfword load (code 001) takes bits 7:0 or 15:0 of the shifted word and copies bit 7 or bit 15 into all higher bits.
- R10: An unsigned byte load (code 100) or unsigned halfword load (code 101) takes bits 7:0 or 15:0 of the shifted word and fills the higher bits with zeros.
- R11: For codes 011, 110 and 111, the loaded value is the shifted word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| size_code | input | 3 | Access width and signedness code |
| addr_lo | input | 2 | Byte offset within the bus word |
| store_en | input | 1 | High while a store transfer is being issued |
| store_data | input | 32 | Operand to be written |
| read_data | input | 32 | Word returned by the bus |
| lane_we | output | 4 | Per-lane write enables |
| wr_data | output | 32 | Lane-replicated write data |
| load_result | output | 32 | Aligned and extended load value |

## Verification
The hardest cases to reach are the corners where an access at a high offset runs past the top lane. Examples are a halfword at offset 3 and a signed byte taken from lane 3 whose bit 7 is set. Both depend on a particular pairing of offset, code and data value.

The stimulus sweeps every code, every offset and both store-enable levels. Each of those combinations is run against data patterns that put a negative byte in each lane, next to positive bytes and next to all-zero and all-one words. Every combination is therefore reached, rather than only the well-aligned ones.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [2:0] {
    ACC_BYTE  = 3'b000,
    ACC_HALF  = 3'b001,
    ACC_WORD  = 3'b010,
    ACC_UBYTE = 3'b100,
    ACC_UHALF = 3'b101
  } acc_code_e;

  // number of lanes a code touches on a store (0 = no lanes)
  function automatic int unsigned code_lane_count(input logic [2:0] code);
    case (code)
      ACC_BYTE, ACC_UBYTE: code_lane_count = 1;
      ACC_HALF, ACC_UHALF: code_lane_count = 2;
      ACC_WORD:            code_lane_count = 4;
      default:             code_lane_count = 0;
    endcase
  endfunction

  // true when the load result must be sign-filled
  function automatic logic code_is_signed(input logic [2:0] code);
    code_is_signed = (code == ACC_BYTE) || (code == ACC_HALF);
  endfunction

  // width in bits kept from a load before extension (0 = keep all)
  function automatic int unsigned code_keep_bits(input logic [2:0] code);
    case (code)
      ACC_BYTE, ACC_UBYTE: code_keep_bits = 8;
      ACC_HALF, ACC_UHALF: code_keep_bits = 16;
      default:             code_keep_bits = 0;
    endcase
  endfunction

endpackage

// File: rtl/store_replicator.sv
module store_replicator
  import lsu_align_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [2:0]              code,
  input  logic [LANE_W*LANES-1:0] data_in,
  output logic [LANE_W*LANES-1:0] data_out
);
  localparam int DW = LANE_W * LANES;

  logic [DW-1:0] byte_fill;
  logic [DW-1:0] half_fill;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign byte_fill[g*LANE_W +: LANE_W] = data_in[LANE_W-1:0];
      assign half_fill[g*LANE_W +: LANE_W] = data_in[(g%2)*LANE_W +: LANE_W];
    end
  endgenerate

  always_comb begin
    case (code)
      ACC_BYTE: data_out = byte_fill;
      ACC_HALF: data_out = half_fill;
      default:  data_out = data_in;
    endcase
  end

  // R1: byte store puts the same value in every lane
  always_comb begin
    if (code == ACC_BYTE) begin
      for (int i = 1; i < LANES; i++) begin
        p_byte_lanes_equal_r1: assert (data_out[i*LANE_W +: LANE_W] == data_out[LANE_W-1:0])
          else $error("byte lanes differ");
      end
    end
  end
endmodule

// File: rtl/strobe_builder.sv
module strobe_builder
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic [2:0]       code,
  input  logic [OFF_W-1:0] offset,
  input  logic             enable,
  output logic [LANES-1:0] lane_we
);
  logic [2*LANES-1:0] base_mask;
  logic [2*LANES-1:0] shifted_mask;
  logic               full_word;

  always_comb begin
    base_mask = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(code_lane_count(code))) base_mask[i] = 1'b1;
    end
  end

  assign full_word    = (code == ACC_WORD);
  assign shifted_mask = full_word ? base_mask : (base_mask << offset);

  // lanes shifted past the top are dropped
  assign lane_we = enable ? shifted_mask[LANES-1:0] : '0;

  // R7: nothing enabled while not storing
  always_comb begin
    if (!enable) begin
      p_no_strobe_idle_r7: assert (lane_we == '0) else $error("strobe while idle");
    end
  end

  // R4: byte store enables exactly one lane
  always_comb begin
    if (enable && (code == ACC_BYTE || code == ACC_UBYTE)) begin
      p_byte_one_lane_r4: assert ($countones(lane_we) == 1) else $error("byte strobe count");
    end
  end

  // R6: word store enables all lanes
  always_comb begin
    if (enable && full_word) begin
      p_word_all_lanes_r6: assert (lane_we == '1) else $error("word strobe");
    end
  end
endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import lsu_align_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int OFF_W  = 2
) (
  input  logic [2:0]              code,
  input  logic [OFF_W-1:0]        offset,
  input  logic [LANE_W*LANES-1:0] rdata,
  output logic [LANE_W*LANES-1:0] result
);
  localparam int DW = LANE_W * LANES;

  logic [DW-1:0] shifted;
  int unsigned   keep;
  logic          fill_bit;

  assign shifted = rdata >> (int'(offset) * LANE_W);

  always_comb begin
    keep     = code_keep_bits(code);
    fill_bit = 1'b0;
    result   = shifted;
    if (keep != 0) begin
      fill_bit = code_is_signed(code) & shifted[keep-1];
      for (int i = 0; i < DW; i++) begin
        if (i >= int'(keep)) result[i] = fill_bit;
      end
    end
  end

  // R10: unsigned narrow loads have zero upper bits
  always_comb begin
    if (code == ACC_UBYTE) begin
      p_ubyte_zero_top_r10: assert (result[DW-1:LANE_W] == '0) else $error("ubyte top");
    end
    if (code == ACC_UHALF) begin
      p_uhalf_zero_top_r10: assert (result[DW-1:2*LANE_W] == '0) else $error("uhalf top");
    end
  end

  // R9: signed byte fill matches its own bit 7
  always_comb begin
    if (code == ACC_BYTE) begin
      p_sbyte_fill_r9: assert (result[DW-1:LANE_W] == {(DW-LANE_W){result[LANE_W-1]}})
        else $error("sbyte fill");
    end
  end
endmodule

// File: rtl/byte_lane_align.sv
module byte_lane_align
  import lsu_align_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [2:0]       size_code,
  input  logic [OFF_W-1:0] addr_lo,
  input  logic             store_en,
  input  logic [DW-1:0]    store_data,
  input  logic [DW-1:0]    read_data,
  output logic [LANES-1:0] lane_we,
  output logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    load_result
);

  store_replicator #(.LANE_W(LANE_W), .LANES(LANES)) u_repl (
    .code     (size_code),
    .data_in  (store_data),
    .data_out (wr_data)
  );

  strobe_builder #(.LANES(LANES), .OFF_W(OFF_W)) u_strb (
    .code    (size_code),
    .offset  (addr_lo),
    .enable  (store_en),
    .lane_we (lane_we)
  );

  load_aligner #(.LANE_W(LANE_W), .LANES(LANES), .OFF_W(OFF_W)) u_load (
    .code   (size_code),
    .offset (addr_lo),
    .rdata  (read_data),
    .result (load_result)
  );

  // R3: codes outside byte/halfword leave write data untouched
  always_comb begin
    if (size_code != ACC_BYTE && size_code != ACC_HALF) begin
      p_wdata_pass_r3: assert (wr_data == store_data) else $error("wdata changed");
    end
  end
endmodule

// File: tb/tb_byte_lane_align.sv
module tb_byte_lane_align;
  logic        clk = 1'b0;
  logic [2:0]  size_code;
  logic [1:0]  addr_lo;
  logic        store_en;
  logic [31:0] store_data, read_data;
  logic [3:0]  lane_we;
  logic [31:0] wr_data, load_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  byte_lane_align dut (
    .size_code(size_code), .addr_lo(addr_lo), .store_en(store_en),
    .store_data(store_data), .read_data(read_data),
    .lane_we(lane_we), .wr_data(wr_data), .load_result(load_result)
  );

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s code=%0d off=%0d en=%0b actual=%h expected=%h",
               req, what, size_code, addr_lo, store_en, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wdata(input int c, input logic [31:0] d);
    if (c == 0) return (d % 256) * 32'h01010101;
    if (c == 1) return (d % 65536) * 32'h00010001;
    return d;
  endfunction

  function automatic logic [3:0] exp_strobe(input int c, input int off, input bit en);
    int n;
    int base;
    logic [3:0] s;
    s = 4'b0000;
    base = off;
    case (c)
      0, 4: n = 1;
      1, 5: n = 2;
      2: begin n = 4; base = 0; end
      default: n = 0;
    endcase
    for (int i = 0; i < 4; i++)
      if (en && i >= base && i < base + n) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_load(input int c, input int off, input logic [31:0] r);
    longint unsigned sh;
    longint unsigned v;
    sh = longint'(r) / (longint'(1) << (8 * off));
    case (c)
      0: begin v = sh % 256;   if (v >= 128)   v = v + 64'hFFFFFF00; end
      1: begin v = sh % 65536; if (v >= 32768) v = v + 64'hFFFF0000; end
      4: v = sh % 256;
      5: v = sh % 65536;
      default: v = sh;
    endcase
    return v[31:0];
  endfunction

  function automatic string strobe_tag(input int c, input bit en);
    if (!en) return "R7";
    if (c == 0 || c == 4) return "R4";
    if (c == 1 || c == 5) return "R5";
    return "R6";
  endfunction

  function automatic string wdata_tag(input int c);
    if (c == 0) return "R1";
    if (c == 1) return "R2";
    return "R3";
  endfunction

  function automatic string load_tag(input int c);
    if (c == 0 || c == 1) return "R9";
    if (c == 4 || c == 5) return "R10";
    if (c == 2) return "R8";
    return "R11";
  endfunction

  logic [31:0] pats [6] = '{32'h00000000, 32'hFFFFFFFF, 32'h80FF7F01,
                            32'h12345678, 32'h7F80807F, 32'hA5C3E1F0};

  initial begin
    size_code = 3'd0; addr_lo = 2'd0; store_en = 1'b0;
    store_data = '0; read_data = '0;
    @(negedge clk);
    check32("R7", "idle strobe", {28'd0, lane_we}, 32'd0);
    check32("R1", "idle wdata", wr_data, 32'd0);
    check32("R9", "idle load", load_result, 32'd0);

    for (int c = 0; c < 8; c++) begin
      for (int off = 0; off < 4; off++) begin
        for (int en = 0; en < 2; en++) begin
          for (int p = 0; p < 6; p++) begin
            @(posedge clk);
            size_code  = c[2:0];
            addr_lo    = off[1:0];
            store_en   = en[0];
            store_data = pats[p];
            read_data  = pats[5 - p] ^ {off[7:0], 24'd0};
            @(negedge clk);
            check32(strobe_tag(c, en[0]), "strobe", {28'd0, lane_we},
                    {28'd0, exp_strobe(c, off, en[0])});
            check32(wdata_tag(c), "wdata", wr_data, exp_wdata(c, store_data));
            check32(load_tag(c), "load", load_result, exp_load(c, off, read_data));
          end
        end
      end
    end

    // R5 corner: halfword at offset 3 keeps only the top lane
    @(posedge clk);
    size_code = 3'b001; addr_lo = 2'd3; store_en = 1'b1;
    @(negedge clk);
    check32("R5", "half off3", {28'd0, lane_we}, 32'h8);
    // R9 corner: negative byte from lane 3
    @(posedge clk);
    size_code = 3'b000; read_data = 32'h80000000;
    @(negedge clk);
    check32("R9", "sbyte lane3", load_result, 32'hFFFFFF80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule